// File: doc/BRIEF.md
# Multi-pin GPIO port with per-pin glitch filter and edge interrupts

This block controls a group of pads. Each pad is owned either by the port's own output logic or by one of several alternate peripheral sources, picked by a per-pin function number. When the port owns a pad, software sets its output-enable and output value. Output values can be written directly, or changed with single-word set, clear and toggle masks.

Every input passes through a two-flop synchronizer. Behind that, each pin has a glitch filter that can be switched on or off for that pin alone. A filtered pin rejects a one-cycle pulse, accepts a pulse of two cycles or more, and adds exactly two cycles of delay. The conditioned level (filtered or not) can be read back. It also feeds a per-pin edge detector, whose trigger mode is rising, falling or any change.

A detected edge sets a sticky flag. Software clears a flag by writing 1 to it. One interrupt line is the OR of all flags whose enable bit is set. Access is through a plain write strobe and a combinational read port. The configuration assumes NPIN*FW <= DW and 3*NPIN <= DW.

Top module: `gpio_filt_port`

## Requirements
- R1: After reset, every function field, output-enable, output value, filter enable, interrupt enable, trigger mode and flag is 0. So pad_oe, pad_out and irq are 0, and every register reads 0.
- R2: The function register (address 0) holds FW bits per pin, pin i at bits [i*FW+FW-1 : i*FW]. Value 0 gives the pad's out/oe to the port registers. Value k>0 takes pad_out[i] from alt_out[(k-1)*NPIN+i] and pad_oe[i] from alt_oe[(k-1)*NPIN+i].
- R3: A write to the mask-operation address (3) carries a set mask in bits [NPIN-1:0], a clear mask in bits [2*NPIN-1:NPIN] and a toggle mask in bits [3*NPIN-1:2*NPIN]. For each pin, clear wins over set and set wins over toggle. This address reads 0.
- R4: The output-enable register (address 1) and the output-value register (address 2) are written directly and read back.
- R5: The level register (address 8, read only) shows the conditioned input. With the filter off, a pad change shows after 2 clock edges. With the filter on, it shows after exactly 4 edges, which is 2 more.
- R6: The filter-enable register (address 4) has one bit per pin. With the bit set, a pad pulse seen for one cycle never reaches the level, and a pulse held for two cycles always does. Pins with the bit clear are unaffected.
- R7: The trigger register (address 6) holds 2 bits per pin, pin i at bits [2i+1:2i]. Encoding: 0 = never, 1 = rising, 2 = falling, 3 = any change of the conditioned level.
- R8: A trigger sets that pin's sticky flag (address 7). Writing 1 to a flag bit clears it. A trigger in the same cycle as the clear leaves the flag set.
- R9: The interrupt-enable register is at address 5. irq is high exactly when some pin has both its flag and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | DW | Read data (combinational) |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |
| alt_out | input | (2^FW-1)*NPIN | Alternate function output values, one NPIN slice per function |
| alt_oe | input | (2^FW-1)*NPIN | Alternate function output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Assertions check the following on every cycle:
- the filter's output only moves to a value the synchronized input held on the two samples before;
- an edge hit always coincides with a level change;
- flags stay set until cleared, clear when written with 1, and rise only on armed pins;
- irq stays low with no enable set;
- after a mask operation, clear and set take effect in their priority order.

Only the bench's scenarios can show the rest: the exact latency counts with and without the filter, the reject and accept of one-cycle and two-cycle pulses, the routing of each function number to its alternate slice, and the collision of a trigger with its own clear. A random phase compares every output against a behavioural model on each clock.

// File: rtl/gpio_filt_pkg.sv
package gpio_filt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_FUNC  = 4'd0;
  localparam logic [ADDR_W-1:0] A_OE    = 4'd1;
  localparam logic [ADDR_W-1:0] A_OUT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_OUTOP = 4'd3;
  localparam logic [ADDR_W-1:0] A_FILT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd5;
  localparam logic [ADDR_W-1:0] A_TRIG  = 4'd6;
  localparam logic [ADDR_W-1:0] A_IFLAG = 4'd7;
  localparam logic [ADDR_W-1:0] A_LEVEL = 4'd8;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_mode_e;

  function automatic logic edge_hit(input trig_mode_e m, input logic cur, input logic prev);
    case (m)
      TRIG_RISE: edge_hit = cur & ~prev;
      TRIG_FALL: edge_hit = ~cur & prev;
      TRIG_ANY:  edge_hit = cur ^ prev;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpf_pin_cond.sv
module gpf_pin_cond
  import gpio_filt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_i,
  input  logic       filt_en,
  input  trig_mode_e mode,
  output logic       level_o,
  output logic       hit_o
);
  logic sync_a, sync_q, agree_q, filt_q, prev_q;

  // filtered value only follows the synchronized input once two samples agree
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a  <= 1'b0;
      sync_q  <= 1'b0;
      agree_q <= 1'b0;
      filt_q  <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync_a  <= pad_i;
      sync_q  <= sync_a;
      agree_q <= sync_q;
      if (sync_q == agree_q) filt_q <= sync_q;
      prev_q  <= level_o;
    end
  end

  assign level_o = filt_en ? filt_q : sync_q;
  assign hit_o   = edge_hit(mode, level_o, prev_q);

  p_filt_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> ($past(sync_q) && $past(sync_q, 2)));
  p_filt_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> (!$past(sync_q) && !$past(sync_q, 2)));
  p_hit_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (level_o != prev_q));
endmodule

// File: rtl/gpf_out_ctrl.sv
module gpf_out_ctrl #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_we,
  input  logic [NPIN-1:0] set_m,
  input  logic [NPIN-1:0] clr_m,
  input  logic [NPIN-1:0] tgl_m,
  input  logic            out_we,
  input  logic [NPIN-1:0] out_d,
  output logic [NPIN-1:0] out_q
);
  // clear beats set, set beats toggle
  function automatic logic [NPIN-1:0] apply_ops(input logic [NPIN-1:0] cur,
      input logic [NPIN-1:0] s, input logic [NPIN-1:0] c, input logic [NPIN-1:0] t);
    apply_ops = ((cur ^ t) | s) & ~c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (op_we)  out_q <= apply_ops(out_q, set_m, clr_m, tgl_m);
    else if (out_we) out_q <= out_d;
  end

  p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_we |=> ((out_q & $past(clr_m)) == '0));
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_we |=> ((~out_q & $past(set_m) & ~$past(clr_m)) == '0));
endmodule

// File: rtl/gpf_irq.sv
module gpf_irq #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] hit,
  input  logic [NPIN-1:0] armed,
  input  logic [NPIN-1:0] clr_m,
  input  logic [NPIN-1:0] ien,
  output logic [NPIN-1:0] flag_q,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_m) | hit;
  end

  assign irq = |(flag_q & ien);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_q) & ~$past(clr_m)) & ~flag_q) == '0));
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_m) & ~$past(hit) & flag_q) == '0));
  p_armed_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(armed)) == '0));
  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: rtl/gpio_filt_port.sv
module gpio_filt_port
  import gpio_filt_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int FW   = 2,
  parameter int DW   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DW-1:0]                rd_data,
  input  logic [NPIN-1:0]              pad_in,
  output logic [NPIN-1:0]              pad_out,
  output logic [NPIN-1:0]              pad_oe,
  input  logic [((1<<FW)-1)*NPIN-1:0]  alt_out,
  input  logic [((1<<FW)-1)*NPIN-1:0]  alt_oe,
  output logic                         irq
);
  localparam int NALT  = (1 << FW) - 1;
  localparam int FUNCW = NPIN * FW;
  localparam int TRIGW = 2 * NPIN;
  localparam int OPW   = 3 * NPIN;

  logic [FUNCW-1:0] func_q;
  logic [TRIGW-1:0] trig_q;
  logic [NPIN-1:0]  oe_q, fen_q, ien_q, out_q, level, hit, armed, flag_q, iflag_clr;
  logic             unused_wr_hi;

  // pad ownership: function 0 keeps the port's own bit, k>0 takes slice k-1
  function automatic logic pick(input logic [NALT*NPIN-1:0] alt, input logic [FW-1:0] f,
                                input int pin, input logic own);
    if (f == '0) pick = own;
    else         pick = alt[(int'(f) - 1) * NPIN + pin];
  endfunction

  assign unused_wr_hi = ^wr_data[DW-1:OPW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      oe_q   <= '0;
      fen_q  <= '0;
      ien_q  <= '0;
      trig_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_FUNC:  func_q <= wr_data[FUNCW-1:0];
        A_OE:    oe_q   <= wr_data[NPIN-1:0];
        A_FILT:  fen_q  <= wr_data[NPIN-1:0];
        A_IEN:   ien_q  <= wr_data[NPIN-1:0];
        A_TRIG:  trig_q <= wr_data[TRIGW-1:0];
        default: ;
      endcase
    end
  end

  gpf_out_ctrl #(.NPIN(NPIN)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_we  (wr_en && (wr_addr == A_OUTOP)),
    .set_m  (wr_data[NPIN-1:0]),
    .clr_m  (wr_data[2*NPIN-1:NPIN]),
    .tgl_m  (wr_data[OPW-1:2*NPIN]),
    .out_we (wr_en && (wr_addr == A_OUT)),
    .out_d  (wr_data[NPIN-1:0]),
    .out_q  (out_q)
  );

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      gpf_pin_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (pad_in[i]),
        .filt_en (fen_q[i]),
        .mode    (trig_mode_e'(trig_q[2*i +: 2])),
        .level_o (level[i]),
        .hit_o   (hit[i])
      );
      assign armed[i]   = (trig_q[2*i +: 2] != 2'd0);
      assign pad_out[i] = pick(alt_out, func_q[i*FW +: FW], i, out_q[i]);
      assign pad_oe[i]  = pick(alt_oe,  func_q[i*FW +: FW], i, oe_q[i]);
    end
  endgenerate

  assign iflag_clr = (wr_en && (wr_addr == A_IFLAG)) ? wr_data[NPIN-1:0] : '0;

  gpf_irq #(.NPIN(NPIN)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .armed  (armed),
    .clr_m  (iflag_clr),
    .ien    (ien_q),
    .flag_q (flag_q),
    .irq    (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_FUNC:  rd_data[FUNCW-1:0] = func_q;
      A_OE:    rd_data[NPIN-1:0]  = oe_q;
      A_OUT:   rd_data[NPIN-1:0]  = out_q;
      A_FILT:  rd_data[NPIN-1:0]  = fen_q;
      A_IEN:   rd_data[NPIN-1:0]  = ien_q;
      A_TRIG:  rd_data[TRIGW-1:0] = trig_q;
      A_IFLAG: rd_data[NPIN-1:0]  = flag_q;
      A_LEVEL: rd_data[NPIN-1:0]  = level;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: tb/gpio_filt_port_tb.sv
`timescale 1ns/1ps
module gpio_filt_port_tb;
  import gpio_filt_pkg::*;
  localparam int N  = 8;
  localparam int FW = 2;
  localparam int DW = 32;
  localparam int NA = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic [NA*N-1:0] alt_out = '0;
  logic [NA*N-1:0] alt_oe = '0;
  logic irq;

  int total = 0;
  int bad = 0;
  bit rot_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_filt_port #(.NPIN(N), .FW(FW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  // behavioural reference state
  logic [N*FW-1:0] m_func;
  logic [2*N-1:0]  m_trig;
  logic [N-1:0]    m_oe, m_out, m_fen, m_ien, m_flag, m_filt, m_cond, m_prev;
  logic [N-1:0]    smp [4];

  task automatic model_clear();
    m_func = '0; m_trig = '0; m_oe = '0; m_out = '0; m_fen = '0; m_ien = '0;
    m_flag = '0; m_filt = '0; m_cond = '0; m_prev = '0;
    for (int k = 0; k < 4; k++) smp[k] = '0;
  endtask

  task automatic model_edge();
    logic [N-1:0] hits;
    if (!rst_n) begin
      model_clear();
      return;
    end
    for (int p = 0; p < N; p++) begin
      int md;
      md = int'(m_trig[2*p +: 2]);
      hits[p] = (md == 1 && m_cond[p] && !m_prev[p]) ||
                (md == 2 && !m_cond[p] && m_prev[p]) ||
                (md == 3 && m_cond[p] != m_prev[p]);
    end
    m_flag = m_flag | hits;
    if (wr_en) begin
      case (wr_addr)
        4'd0: m_func = wr_data[N*FW-1:0];
        4'd1: m_oe   = wr_data[N-1:0];
        4'd2: m_out  = wr_data[N-1:0];
        4'd3: for (int p = 0; p < N; p++) begin
                if (wr_data[N+p])        m_out[p] = 1'b0;
                else if (wr_data[p])     m_out[p] = 1'b1;
                else if (wr_data[2*N+p]) m_out[p] = ~m_out[p];
              end
        4'd4: m_fen  = wr_data[N-1:0];
        4'd5: m_ien  = wr_data[N-1:0];
        4'd6: m_trig = wr_data[2*N-1:0];
        4'd7: m_flag = m_flag & ~(wr_data[N-1:0] & ~hits);
        default: ;
      endcase
    end
    m_prev = m_cond;
    smp[3] = smp[2]; smp[2] = smp[1]; smp[1] = smp[0]; smp[0] = pad_in;
    for (int p = 0; p < N; p++) begin
      if (smp[2][p] == smp[3][p]) m_filt[p] = smp[2][p];
      m_cond[p] = m_fen[p] ? m_filt[p] : smp[1][p];
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(input logic [3:0] a);
    exp_rd = '0;
    case (a)
      4'd0: exp_rd[N*FW-1:0] = m_func;
      4'd1: exp_rd[N-1:0] = m_oe;
      4'd2: exp_rd[N-1:0] = m_out;
      4'd4: exp_rd[N-1:0] = m_fen;
      4'd5: exp_rd[N-1:0] = m_ien;
      4'd6: exp_rd[2*N-1:0] = m_trig;
      4'd7: exp_rd[N-1:0] = m_flag;
      4'd8: exp_rd[N-1:0] = m_cond;
      default: exp_rd = '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: tag_of = "R2";
      4'd1, 4'd2: tag_of = "R4";
      4'd3: tag_of = "R3";
      4'd4: tag_of = "R6";
      4'd5: tag_of = "R9";
      4'd6: tag_of = "R7";
      4'd7: tag_of = "R8";
      4'd8: tag_of = "R5";
      default: tag_of = "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [N-1:0] eo, ee;
    for (int p = 0; p < N; p++) begin
      int f;
      f = int'(m_func[p*FW +: FW]);
      eo[p] = (f == 0) ? m_out[p] : alt_out[(f-1)*N + p];
      ee[p] = (f == 0) ? m_oe[p]  : alt_oe[(f-1)*N + p];
    end
    chk("R2 pad_out", {24'h0, pad_out}, {24'h0, eo});
    chk("R2 pad_oe",  {24'h0, pad_oe},  {24'h0, ee});
    chk("R9 irq", {31'h0, irq}, {31'h0, |(m_flag & m_ien)});
    chk(tag_of(rd_addr), rd_data, exp_rd(rd_addr));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    if (rot_en) rd_addr = (rd_addr >= 4'd9) ? 4'd0 : rd_addr + 4'd1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 9; a++) begin
      rd_addr = 4'(a); #1;
      chk("R1 register", rd_data, 32'h0);
    end
    // R4 direct output write
    wr(A_OE, 32'hFF);
    wr(A_OUT, 32'hA5);
    chk("R4 out", {24'h0, pad_out}, 32'hA5);
    rd_addr = A_OUT; #1;
    chk("R4 readback", rd_data, 32'hA5);
    // R3 mask priority: set 0F, clear 03, toggle F4 on A5 -> 5C
    wr(A_OUTOP, 32'h00F4030F);
    chk("R3 priority", {24'h0, pad_out}, 32'h5C);
    // R2 ownership
    alt_out = 24'h000002;
    alt_oe  = 24'h040000;
    wr(A_FUNC, 32'h34);
    chk("R2 alt out", {24'h0, pad_out}, 32'h5A);
    chk("R2 alt oe", {24'h0, pad_oe}, 32'hFD);
    wr(A_FUNC, 32'h0);
    chk("R2 back to port", {24'h0, pad_out}, 32'h5C);
    // R5 latency
    rd_addr = A_LEVEL;
    repeat (6) tick();
    pad_in[0] = 1'b1; tick();
    chk("R5 unfiltered edge1", {31'h0, rd_data[0]}, 32'h0);
    tick();
    chk("R5 unfiltered edge2", {31'h0, rd_data[0]}, 32'h1);
    pad_in[0] = 1'b0; repeat (4) tick();
    wr(A_FILT, 32'h01);
    repeat (3) tick();
    pad_in[0] = 1'b1; repeat (3) tick();
    chk("R5 filtered edge3", {31'h0, rd_data[0]}, 32'h0);
    tick();
    chk("R5 filtered edge4", {31'h0, rd_data[0]}, 32'h1);
    pad_in[0] = 1'b0; repeat (6) tick();
    // R6 reject one-cycle pulse
    pad_in[0] = 1'b1; tick(); pad_in[0] = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R6 reject", {31'h0, rd_data[0]}, 32'h0);
    end
    // R6 accept two-cycle pulse
    pad_in[0] = 1'b1; tick(); tick(); pad_in[0] = 1'b0; tick(); tick();
    chk("R6 accept", {31'h0, rd_data[0]}, 32'h1);
    repeat (6) tick();
    // R6 unfiltered neighbour passes a one-cycle pulse
    pad_in[1] = 1'b1; tick(); pad_in[1] = 1'b0; tick();
    chk("R6 per-pin on", {31'h0, rd_data[1]}, 32'h1);
    tick();
    chk("R6 per-pin off", {31'h0, rd_data[1]}, 32'h0);
    repeat (4) tick();
    // R7 trigger modes: pin0 rise, pin1 fall, pin2 any, pin3 off
    wr(A_FILT, 32'h0);
    repeat (4) tick();
    wr(A_TRIG, 32'h39);
    rd_addr = A_IFLAG;
    pad_in = 8'h0F; repeat (4) tick();
    chk("R7 rise/any", rd_data, 32'h05);
    pad_in = 8'h00; repeat (4) tick();
    chk("R7 fall/any/off", rd_data, 32'h07);
    // R8 clear by writing 1
    wr(A_IFLAG, 32'h01);
    chk("R8 w1c", rd_data, 32'h06);
    // R8 trigger in the same cycle as the clear
    pad_in[0] = 1'b1; tick(); tick();
    wr(A_IFLAG, 32'h01);
    chk("R8 set beats clear", rd_data, 32'h07);
    // R9 interrupt combine
    wr(A_IEN, 32'h00);
    chk("R9 none enabled", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h08);
    chk("R9 flag absent", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h02);
    chk("R9 raised", {31'h0, irq}, 32'h1);
    wr(A_IFLAG, 32'h02);
    chk("R9 cleared", {31'h0, irq}, 32'h0);
    // random phase against the model
    rot_en = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 3) == 0) pad_in[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) begin
        alt_out = 24'($urandom);
        alt_oe  = 24'($urandom);
      end
      if ($urandom_range(0, 2) == 0) begin
        wr_en = 1'b1; wr_addr = 4'($urandom_range(0, 9)); wr_data = $urandom;
      end
      tick();
      wr_en = 1'b0;
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule